// File: doc/BRIEF.md
# Transmit FIFO Index Manager

This block keeps the read and write positions of a circular transmit queue. The queue is made of up to 32 message slots in a shared message memory. Software claims one or more consecutive slots with a request bitmap. The protocol engine reports each finished transmission. Either side may withdraw pending requests with a cancel bitmap. From these events the block works out the free slot count, the full and empty flags, the pending bit of every slot, and the word address at which the next message is to be written.

The queue depth, the slot size and the base address are run-time settings. All index arithmetic wraps at the configured depth. Empty and full are kept apart by an occupancy counter, so equal read and write positions never leave the state in doubt. If the slot at the read position is withdrawn, the read position jumps ahead to the next slot that still waits to be sent. A withdrawal anywhere else only clears that slot's pending bit.

Top module: `tx_fifo_idx_mgr`

## Requirements
- R1: Asynchronous reset (rst_ni low) clears both indices to 0 and all pending bits. After reset, free_lvl_o equals cfg_depth_i, empty_o is 1, full_o is 0 and add_err_o is 0.
- R2: An add request sets bit i of add_req_i for each of n slots. The set bits must be exactly the n consecutive slots that start at put_idx_o and wrap at cfg_depth_i. One cycle later, put_idx_o has advanced by n modulo the depth, free_lvl_o has dropped by n, and those n pending bits are set.
- R3: An add request is rejected as a whole if n exceeds free_lvl_o or if the bitmap differs from that consecutive pattern, including any bit at or above the depth. A rejected request raises add_err_o for exactly one cycle and leaves the indices, the free level and the pending bits unchanged.
- R4: A tx_done_i pulse with a non-empty queue advances get_idx_o by one modulo the depth, raises free_lvl_o by one and clears the pending bit of the slot it left. When the queue is empty, tx_done_i has no effect.
- R5: full_o is 1 exactly when free_lvl_o is 0, and empty_o is 1 exactly when free_lvl_o equals the depth. Once set, full_o stays set until a completion or a head cancel frees a slot.
- R6: A cancel bit for the slot at get_idx_o, with a non-empty queue and no completion in the same cycle, moves get_idx_o to the first later occupied slot whose pending bit is still set after this cycle's cancels. free_lvl_o rises by the distance moved. If no such slot exists, get_idx_o becomes put_idx_o and the queue becomes empty.
- R7: A cancel bit for any slot other than the one at get_idx_o clears that slot's pending bit and leaves get_idx_o and free_lvl_o unchanged.
- R8: A completion and an accepted add in the same cycle are both applied, so free_lvl_o changes by 1 − n. The admission check uses the free level from before the completion.
- R9: When a completion and a cancel of the head slot fall in the same cycle, the completion decides the move: get_idx_o advances by exactly one.
- R10: next_addr_o equals cfg_base_i + put_idx_o × cfg_esize_i, in 32-bit words, and follows the configuration inputs combinationally.
- R11: With a depth below 32, every index and every slot run wraps at the configured depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_depth_i | input | 6 | Number of slots in use (1 to 32) |
| cfg_base_i | input | 16 | Word address of slot 0 |
| cfg_esize_i | input | 5 | Slot size in 32-bit words |
| add_req_i | input | 32 | Per-slot add request bitmap |
| tx_done_i | input | 1 | Transmission of the head slot finished |
| cancel_i | input | 32 | Per-slot cancel bitmap |
| get_idx_o | output | 5 | Slot that is sent next |
| put_idx_o | output | 5 | Slot that is written next |
| free_lvl_o | output | 6 | Number of free slots |
| full_o | output | 1 | No free slot |
| empty_o | output | 1 | No occupied slot |
| pend_o | output | 32 | Pending request bit per slot |
| next_addr_o | output | 16 | Word address of the next free slot |
| add_err_o | output | 1 | One-cycle pulse on a rejected add |

## Verification
A completion can fall in the same cycle as an add, and a completion can fall in the same cycle as a cancel of the head slot. The bench drives tx_done_i together with a one-slot add while the queue is nearly full, and expects both index moves and a free level that has changed by zero. It also drives tx_done_i together with a cancel of the head slot and expects the read index to move by exactly one. In both cases the pending bits are compared slot by slot.

// File: rtl/txf_pkg.sv
package txf_pkg;
  parameter int unsigned SLOTS = 32;
  localparam int unsigned IDX_W = $clog2(SLOTS);
  localparam int unsigned CNT_W = IDX_W + 1;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [SLOTS-1:0] map_t;
endpackage

// File: rtl/txf_req_check.sv
module txf_req_check
  import txf_pkg::*;
(
  input  map_t req_i,
  input  idx_t put_i,
  input  cnt_t depth_i,
  input  cnt_t free_i,
  output cnt_t n_o,
  output logic ok_o,
  output logic bad_o,
  output map_t mask_o
);
  cnt_t n;
  map_t exp_mask;

  always_comb begin
    n = '0;
    for (int i = 0; i < SLOTS; i++) n = n + cnt_t'(req_i[i]);
  end

  // expected run: n slots from put, wrapping at depth
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    cnt_t slot, off;
    assign slot = cnt_t'(g);
    assign off  = (slot >= cnt_t'(put_i)) ? slot - cnt_t'(put_i)
                                          : slot + depth_i - cnt_t'(put_i);
    assign exp_mask[g] = (slot < depth_i) && (off < n);
  end

  assign ok_o   = (|req_i) && (n <= free_i) && (req_i == exp_mask);
  assign bad_o  = (|req_i) && !ok_o;
  assign mask_o = ok_o ? req_i : '0;
  assign n_o    = n;
endmodule

// File: rtl/txf_pending.sv
module txf_pending
  import txf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  map_t cancel_i,
  input  map_t set_i,
  input  logic done_i,
  input  idx_t get_i,
  input  cnt_t cnt_i,
  input  cnt_t depth_i,
  output map_t pend_o,
  output logic skip_o,
  output cnt_t dist_o
);
  map_t pend_q, kept, pend_d;
  cnt_t kk, s;
  logic found;

  assign kept = pend_q & ~cancel_i;

  // distance from head to first still-pending occupied slot
  always_comb begin
    dist_o = cnt_i;
    found  = 1'b0;
    kk     = '0;
    s      = '0;
    for (int k = 1; k < SLOTS; k++) begin
      kk = cnt_t'(k);
      s  = cnt_t'(get_i) + kk;
      if (s >= depth_i) s = s - depth_i;
      if (!found && (kk < cnt_i) && kept[idx_t'(s)]) begin
        dist_o = kk;
        found  = 1'b1;
      end
    end
  end

  assign skip_o = (cnt_i != '0) && cancel_i[get_i] && !done_i;

  always_comb begin
    pend_d = kept | set_i;
    if (done_i) pend_d[get_i] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  assert_cancel_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(cancel_i & ~set_i)) |=> ((pend_q & $past(cancel_i & ~set_i)) == '0));

  assert_add_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/txf_ptrs.sv
module txf_ptrs
  import txf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t depth_i,
  input  logic done_i,
  input  logic skip_i,
  input  cnt_t dist_i,
  input  logic acc_i,
  input  cnt_t n_i,
  input  logic bad_i,
  output idx_t get_o,
  output idx_t put_o,
  output cnt_t cnt_o,
  output logic err_o
);
  idx_t get_q, put_q;
  cnt_t cnt_q, get_sum, put_sum, rel;
  logic err_q;

  assign rel     = done_i ? cnt_t'(1) : (skip_i ? dist_i : '0);
  assign get_sum = cnt_t'(get_q) + rel;
  assign put_sum = cnt_t'(put_q) + (acc_i ? n_i : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      get_q <= '0;
      put_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      get_q <= idx_t'((get_sum >= depth_i) ? get_sum - depth_i : get_sum);
      put_q <= idx_t'((put_sum >= depth_i) ? put_sum - depth_i : put_sum);
      cnt_q <= cnt_q - rel + (acc_i ? n_i : '0);
      err_q <= bad_i;
    end
  end

  assign get_o = get_q;
  assign put_o = put_q;
  assign cnt_o = cnt_q;
  assign err_o = err_q;

  assert_empty_ptrs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> (get_q == put_q));

  assert_full_ptrs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == depth_i) |-> (get_q == put_q));

  assert_full_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q == depth_i) && !done_i && !skip_i) |=> (cnt_q == $past(cnt_q)));

  assert_done_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !acc_i) |=> (cnt_q == $past(cnt_q) - cnt_t'(1)));

  assert_reject_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (put_q == $past(put_q)));
endmodule

// File: rtl/txf_addr.sv
module txf_addr
  import txf_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned ESZ_W  = 5
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ESZ_W-1:0]  esize_i,
  input  idx_t              put_i,
  output logic [ADDR_W-1:0] addr_o
);
  assign addr_o = base_i + ADDR_W'(put_i) * ADDR_W'(esize_i);
endmodule

// File: rtl/tx_fifo_idx_mgr.sv
module tx_fifo_idx_mgr
  import txf_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned ESZ_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cfg_depth_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ESZ_W-1:0]  cfg_esize_i,
  input  logic [SLOTS-1:0]  add_req_i,
  input  logic              tx_done_i,
  input  logic [SLOTS-1:0]  cancel_i,
  output logic [IDX_W-1:0]  get_idx_o,
  output logic [IDX_W-1:0]  put_idx_o,
  output logic [CNT_W-1:0]  free_lvl_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [SLOTS-1:0]  pend_o,
  output logic [ADDR_W-1:0] next_addr_o,
  output logic              add_err_o
);
  idx_t get_w, put_w;
  cnt_t cnt_w, free_w, n_w, dist_w;
  map_t set_w;
  logic acc_w, bad_w, skip_w, done_w;

  assign free_w = cfg_depth_i - cnt_w;
  assign done_w = tx_done_i && (cnt_w != '0);

  txf_req_check u_req (
    .req_i  (add_req_i),
    .put_i  (put_w),
    .depth_i(cfg_depth_i),
    .free_i (free_w),
    .n_o    (n_w),
    .ok_o   (acc_w),
    .bad_o  (bad_w),
    .mask_o (set_w)
  );

  txf_pending u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cancel_i(cancel_i),
    .set_i   (set_w),
    .done_i  (done_w),
    .get_i   (get_w),
    .cnt_i   (cnt_w),
    .depth_i (cfg_depth_i),
    .pend_o  (pend_o),
    .skip_o  (skip_w),
    .dist_o  (dist_w)
  );

  txf_ptrs u_ptrs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .depth_i(cfg_depth_i),
    .done_i (done_w),
    .skip_i (skip_w),
    .dist_i (dist_w),
    .acc_i  (acc_w),
    .n_i    (n_w),
    .bad_i  (bad_w),
    .get_o  (get_w),
    .put_o  (put_w),
    .cnt_o  (cnt_w),
    .err_o  (add_err_o)
  );

  txf_addr #(.ADDR_W(ADDR_W), .ESZ_W(ESZ_W)) u_addr (
    .base_i (cfg_base_i),
    .esize_i(cfg_esize_i),
    .put_i  (put_w),
    .addr_o (next_addr_o)
  );

  assign get_idx_o  = get_w;
  assign put_idx_o  = put_w;
  assign free_lvl_o = free_w;
  assign full_o     = (cnt_w == cfg_depth_i);
  assign empty_o    = (cnt_w == '0);

  assert_err_no_add_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_err_o |-> (free_lvl_o == $past(free_lvl_o) + cnt_t'($past(done_w))
                   + ($past(skip_w) ? $past(dist_w) : '0)));
endmodule

// File: tb/tx_fifo_idx_mgr_tb_top.sv
`timescale 1ns/1ps
module tx_fifo_idx_mgr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  depth = 6'd8;
  logic [15:0] base = 16'h0100;
  logic [4:0]  esize = 5'd4;
  logic [31:0] add_req = '0;
  logic        done = 1'b0;
  logic [31:0] cancel = '0;
  logic [4:0]  get_idx, put_idx;
  logic [5:0]  free_lvl;
  logic        full, empty, add_err;
  logic [31:0] pend;
  logic [15:0] next_addr;
  int nvec = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  tx_fifo_idx_mgr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_depth_i(depth), .cfg_base_i(base),
    .cfg_esize_i(esize), .add_req_i(add_req), .tx_done_i(done), .cancel_i(cancel),
    .get_idx_o(get_idx), .put_idx_o(put_idx), .free_lvl_o(free_lvl), .full_o(full),
    .empty_o(empty), .pend_o(pend), .next_addr_o(next_addr), .add_err_o(add_err)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_st(input string tag, input int g, input int p, input int f,
                        input logic fu, input logic em, input logic [31:0] pd,
                        input logic er);
    chk(tag, "get", 32'(get_idx), 32'(g));
    chk(tag, "put", 32'(put_idx), 32'(p));
    chk(tag, "free", 32'(free_lvl), 32'(f));
    chk(tag, "full", 32'(full), 32'(fu));
    chk(tag, "empty", 32'(empty), 32'(em));
    chk(tag, "pend", pend, pd);
    chk(tag, "err", 32'(add_err), 32'(er));
  endtask

  task automatic apply(input logic [31:0] a, input logic d, input logic [31:0] c);
    @(negedge clk);
    add_req = a; done = d; cancel = c;
    @(negedge clk);
    add_req = '0; done = 1'b0; cancel = '0;
  endtask

  task automatic do_reset(input logic [5:0] dep);
    @(negedge clk);
    rst_n = 1'b0; depth = dep;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk_st("R1", 0, 0, 8, 0, 1, 32'h0, 0);
    chk("R10", "addr", 32'(next_addr), 32'h0100);
  endtask

  task automatic t_add_three;
    apply(32'h07, 0, 0);
    chk_st("R2", 0, 3, 5, 0, 0, 32'h07, 0);
    chk("R10", "addr", 32'(next_addr), 32'h010C);
  endtask

  task automatic t_bad_pattern;
    apply(32'h10, 0, 0);
    chk_st("R3", 0, 3, 5, 0, 0, 32'h07, 1);
    apply(0, 0, 0);
    chk("R3", "err pulse end", 32'(add_err), 0);
  endtask

  task automatic t_done;
    apply(0, 1, 0);
    chk_st("R4", 1, 3, 6, 0, 0, 32'h06, 0);
  endtask

  task automatic t_cancel_other;
    apply(0, 0, 32'h04);
    chk_st("R7", 1, 3, 6, 0, 0, 32'h02, 0);
  endtask

  task automatic t_done_and_add;
    apply(32'hF8, 0, 0);
    chk_st("R2", 1, 0, 1, 0, 0, 32'hFA, 0);
    apply(32'h01, 1, 0);
    chk_st("R8", 2, 1, 1, 0, 0, 32'hF9, 0);
  endtask

  task automatic t_head_cancel;
    apply(0, 0, 32'h04);
    chk_st("R6", 3, 1, 2, 0, 0, 32'hF9, 0);
  endtask

  task automatic t_full;
    apply(32'h06, 0, 0);
    chk_st("R5", 3, 3, 0, 1, 0, 32'hFF, 0);
    apply(32'h08, 0, 0);
    chk_st("R3", 3, 3, 0, 1, 0, 32'hFF, 1);
    apply(0, 0, 0);
    chk("R5", "full held", 32'(full), 1);
  endtask

  task automatic t_done_and_head_cancel;
    apply(0, 1, 32'h08);
    chk_st("R9", 4, 3, 1, 0, 0, 32'hF7, 0);
  endtask

  task automatic t_multi_skip;
    apply(0, 0, 32'h70);
    chk_st("R6", 7, 3, 4, 0, 0, 32'h87, 0);
    apply(0, 0, 32'h87);
    chk_st("R6", 3, 3, 8, 0, 1, 32'h0, 0);
  endtask

  task automatic t_done_empty;
    apply(0, 1, 0);
    chk_st("R4", 3, 3, 8, 0, 1, 32'h0, 0);
  endtask

  task automatic t_addr;
    chk("R10", "addr put3", 32'(next_addr), 32'h010C);
    @(negedge clk);
    base = 16'h0200; esize = 5'd6;
    #1;
    chk("R10", "addr reconfig", 32'(next_addr), 32'h0212);
  endtask

  task automatic t_wrap5;
    do_reset(6'd5);
    chk_st("R1", 0, 0, 5, 0, 1, 32'h0, 0);
    apply(32'h0F, 0, 0);
    chk_st("R11", 0, 4, 1, 0, 0, 32'h0F, 0);
    apply(32'h20, 0, 0);
    chk_st("R3", 0, 4, 1, 0, 0, 32'h0F, 1);
    apply(0, 1, 0);
    apply(0, 1, 0);
    chk_st("R11", 2, 4, 3, 0, 0, 32'h0C, 0);
    apply(32'h13, 0, 0);
    chk_st("R11", 2, 2, 0, 1, 0, 32'h1F, 0);
  endtask

  initial begin
    #(8 * 100000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    do_reset(6'd8);
    t_reset();
    t_add_three();
    t_bad_pattern();
    t_done();
    t_cancel_other();
    t_done_and_add();
    t_head_cancel();
    t_full();
    t_done_and_head_cancel();
    t_multi_skip();
    t_done_empty();
    t_addr();
    t_wrap5();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule